// File: doc/BRIEF.md
# Processor Interrupt Interface

This block sits between an interrupt distributor and one processor. The distributor forwards every candidate interrupt together with its priority, its trigger type, and (for software-generated IDs) the number of the processor that raised it. The block picks the most urgent candidate that may be signalled and raises a request line to the processor.

The processor uses a small 32-bit register port with four registers:

| Byte offset | Register | Access |
|---|---|---|
| 0x00 | control: bit 0 enables the request line | read/write |
| 0x04 | priority threshold, 8 bits | read/write |
| 0x0C | acknowledge word | read |
| 0x10 | end-of-interrupt | write |

Reading the acknowledge word takes the winner and makes it active. Writing end-of-interrupt retires it. An interrupt stays active, and is not offered again, until its end-of-interrupt is written. Edge-type sources latch a one-cycle request pulse as pending, and the acknowledge clears that pending state. Level-type sources are pending for as long as their request input is high.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset the control enable and the threshold are 0, nothing is active, `irq_o` is low and an acknowledge read returns 1023.
- R2: `irq_o` is high exactly when control bit 0 is set and at least one ID is pending, not active, and has a priority below the threshold. With bit 0 clear, the line stays low.
- R3: The threshold comparison is strict. An ID whose priority value equals the threshold is neither signalled nor acknowledged.
- R4: Among the qualifying IDs, the numerically lowest priority value wins. When values are equal, the lowest ID wins.
- R5: The acknowledge word carries the ID in bits [9:0]. For IDs 0-15 it carries the requesting processor number in bits [12:10]. For other IDs those bits are zero, and bits [31:13] are always zero.
- R6: When nothing qualifies, or when control bit 0 is clear, an acknowledge read returns 1023 and changes no state.
- R7: An acknowledge marks the winner active and clears its pending state if it is edge-type. An active ID is not signalled or returned again until its end-of-interrupt.
- R8: A level-type source whose request is still high after its end-of-interrupt is signalled and returned again.
- R9: An end-of-interrupt write whose bits [9:0] name an ID that is not active, or that lies outside the implemented range, changes nothing.
- R10: An edge pulse for an ID that arrives in the same cycle as that ID's acknowledge is kept as pending. The ID is returned again after its end-of-interrupt.
- R11: The control register (bit 0) and the threshold register (bits [7:0]) read back the values written, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_req | input | NUM_IRQ | Per-ID request: a level for level-type IDs, a one-cycle pulse for edge-type IDs |
| fwd_edge | input | NUM_IRQ | Per-ID trigger type, 1 = edge |
| fwd_prio | input | NUM_IRQ*8 | Per-ID priority, ID i at bits [8i+7:8i] |
| fwd_src | input | 48 | Requesting processor of IDs 0-15, ID i at bits [3i+2:3i] |
| reg_addr | input | 5 | Register byte offset |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The collision that matters here is an edge-type request pulse landing in the same cycle as the acknowledge read that takes the same ID. In that cycle, the pending state of that ID is both set and cleared. The bench provokes this by raising the ID's request during the acknowledge read strobe. It then checks three things: the line stays low while the ID is active, it rises again after end-of-interrupt, and a second acknowledge returns the same ID. A lost pulse would instead show up as the spurious value.

// File: rtl/cpu_irq_port.sv
module cpu_irq_port #(
  parameter int NUM_IRQ = 48,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        fwd_req,
  input  logic [NUM_IRQ-1:0]        fwd_edge,
  input  logic [NUM_IRQ*PRIO_W-1:0] fwd_prio,
  input  logic [47:0]               fwd_src,
  input  logic [4:0]                reg_addr,
  input  logic                      reg_rd,
  input  logic                      reg_wr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      irq_o
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam int ID_W  = 10;
  localparam int SRC_W = 3;
  localparam int SGI_N = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_PMASK = 3'd1, A_ACK = 3'd3, A_EOI = 3'd4;

  logic               ctrl_en;
  logic [PRIO_W-1:0]  pmask;
  logic [NUM_IRQ-1:0] edge_pend, active, pend, cand;
  logic [NUM_IRQ-1:0] ack_hot, eoi_hot;
  logic               best_v, win_ok;
  logic [IDX_W-1:0]   best_idx;
  logic [PRIO_W-1:0]  best_p;
  logic [SRC_W-1:0]   win_src;
  logic [31:0]        ack_word;
  logic [ID_W-1:0]    eoi_id;
  logic               ack_take, eoi_take, sel_ack, sel_eoi;

  assign sel_ack = reg_addr[4:2] == A_ACK;
  assign sel_eoi = reg_addr[4:2] == A_EOI;

  assign pend = (edge_pend & fwd_edge) | (fwd_req & ~fwd_edge);

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++)
      cand[i] = pend[i] && !active[i] && (fwd_prio[i*PRIO_W +: PRIO_W] < pmask);
  end

  always_comb begin
    best_v   = 1'b0;
    best_idx = '0;
    best_p   = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!best_v || fwd_prio[i*PRIO_W +: PRIO_W] < best_p)) begin
        best_v   = 1'b1;
        best_idx = IDX_W'(i);
        best_p   = fwd_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign win_ok  = ctrl_en && best_v;
  assign irq_o   = win_ok;
  assign win_src = (int'(best_idx) < SGI_N) ? fwd_src[int'(best_idx[3:0])*SRC_W +: SRC_W] : '0;
  assign ack_word = win_ok ? {19'd0, win_src, {(ID_W-IDX_W){1'b0}}, best_idx} : 32'd1023;

  always_comb begin
    case (reg_addr[4:2])
      A_CTRL:  reg_rdata = {31'd0, ctrl_en};
      A_PMASK: reg_rdata = 32'(pmask);
      A_ACK:   reg_rdata = ack_word;
      default: reg_rdata = '0;
    endcase
  end

  assign eoi_id   = reg_wdata[ID_W-1:0];
  assign ack_take = reg_rd && sel_ack && win_ok;
  assign eoi_take = reg_wr && sel_eoi && (eoi_id < ID_W'(NUM_IRQ)) && active[eoi_id[IDX_W-1:0]];
  assign ack_hot  = ack_take ? (NUM_IRQ'(1) << best_idx) : '0;
  assign eoi_hot  = eoi_take ? (NUM_IRQ'(1) << eoi_id[IDX_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      pmask     <= '0;
      edge_pend <= '0;
      active    <= '0;
    end else begin
      if (reg_wr && reg_addr[4:2] == A_CTRL)  ctrl_en <= reg_wdata[0];
      if (reg_wr && reg_addr[4:2] == A_PMASK) pmask   <= reg_wdata[PRIO_W-1:0];
      edge_pend <= ((edge_pend & ~ack_hot) | (fwd_req & fwd_edge)) & fwd_edge;
      active    <= (active | ack_hot) & ~eoi_hot;
    end
  end
endmodule

module cpu_irq_port_chk #(
  parameter int NUM_IRQ = 48,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [4:0]         reg_addr,
  input logic               reg_rd,
  input logic               reg_wr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic               irq_o,
  input logic               ctrl_en,
  input logic               win_ok,
  input logic [IDX_W-1:0]   best_idx,
  input logic [NUM_IRQ-1:0] active
);
  logic is_ack, is_eoi, eoi_live;
  assign is_ack   = reg_addr[4:2] == 3'd3;
  assign is_eoi   = reg_addr[4:2] == 3'd4;
  assign eoi_live = (reg_wdata[9:0] < 10'(NUM_IRQ)) && active[reg_wdata[IDX_W-1:0]];

  a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_en);
  a_r7_ack_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && is_ack && win_ok) |=> active[$past(best_idx)]);
  a_r7_winner_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |-> !active[best_idx]);
  a_r6_spurious_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && is_ack && !win_ok && !reg_wr) |=> $stable(active));
  a_r6_spurious_code: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && is_ack && !win_ok) |-> reg_rdata == 32'd1023);
  a_r9_eoi_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && is_eoi && !eoi_live && !reg_rd) |=> $stable(active));
  a_r5_ack_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && is_ack) |-> reg_rdata[31:13] == 19'd0);
endmodule

bind cpu_irq_port cpu_irq_port_chk #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .ctrl_en(ctrl_en),
  .win_ok(win_ok), .best_idx(best_idx), .active(active)
);

// File: tb/cpu_irq_port_tb_top.sv
module cpu_irq_port_tb_top;
  localparam int N = 48;
  localparam logic [4:0] A_CTRL = 5'h00, A_PMASK = 5'h04, A_ACK = 5'h0C, A_EOI = 5'h10;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] fwd_req = '0, fwd_edge = '0;
  logic [N*8-1:0] fwd_prio;
  logic [47:0] fwd_src = '0;
  logic [4:0] reg_addr = '0;
  logic reg_rd = 0, reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_o;
  logic [7:0] prio_tb [N];

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) fwd_prio[i*8 +: 8] = prio_tb[i];

  cpu_irq_port #(.NUM_IRQ(N)) dut_i (.*);

  always @(negedge clk) begin
    if (reg_rd && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    reg_rd = 1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic rd_pulse(input int id, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    reg_rd = 1; reg_addr = A_ACK; fwd_req[id] = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    reg_rd = 0; fwd_req[id] = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic pulse(input int id);
    @(posedge clk); #1; fwd_req[id] = 1;
    @(posedge clk); #1; fwd_req[id] = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq_o got %b expected %b", t, irq_o, e);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < N; i++) prio_tb[i] = 8'hA0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_irq(0, "R1 reset line");
    rd(A_CTRL, 0, "R1 ctrl reset");
    rd(A_PMASK, 0, "R1 threshold reset");
    rd(A_ACK, 1023, "R1 ack after reset");

    wr(A_PMASK, 32'hFFFF_FFF0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_PMASK, 32'hF0, "R11 threshold readback");
    rd(A_CTRL, 1, "R11 ctrl readback");

    @(posedge clk); #1 fwd_req[40] = 1;
    chk_irq(1, "R2 level pending signalled");
    wr(A_CTRL, 0);
    chk_irq(0, "R2 disabled line low");
    rd(A_ACK, 1023, "R6 ack while disabled");
    wr(A_CTRL, 1);

    prio_tb[40] = 8'hF0;
    chk_irq(0, "R3 equal to threshold");
    rd(A_ACK, 1023, "R3 equal not acked");
    prio_tb[40] = 8'hEF;
    chk_irq(1, "R3 just below threshold");

    @(posedge clk); #1;
    prio_tb[35] = 8'h80; prio_tb[20] = 8'h80;
    fwd_req[35] = 1; fwd_req[20] = 1;
    rd(A_ACK, 20, "R4 tie lowest id");
    rd(A_ACK, 35, "R4 next priority");
    rd(A_ACK, 40, "R4 least urgent last");
    rd(A_ACK, 1023, "R7 active not re-presented");
    chk_irq(0, "R7 all active line low");

    wr(A_EOI, 35);
    chk_irq(1, "R8 level re-signalled");
    rd(A_ACK, 35, "R8 level re-acked");
    @(posedge clk); #1 fwd_req[35] = 0; fwd_req[40] = 0;
    wr(A_EOI, 35);
    wr(A_EOI, 40);
    rd(A_ACK, 1023, "R8 dropped level gone");

    wr(A_EOI, 21);
    wr(A_EOI, 1000);
    rd(A_ACK, 1023, "R9 stray eoi ignored");
    chk_irq(0, "R9 line stays low");
    wr(A_EOI, 20);
    rd(A_ACK, 20, "R9 real eoi retires");
    @(posedge clk); #1 fwd_req[20] = 0;
    wr(A_EOI, 20);

    @(posedge clk); #1;
    fwd_edge[5] = 1; fwd_src[15 +: 3] = 3'd6;
    pulse(5);
    chk_irq(1, "R7 edge latched");
    rd(A_ACK, (6 << 10) | 5, "R5 software id with source");
    chk_irq(0, "R7 edge cleared on ack");
    wr(A_EOI, (6 << 10) | 5);
    rd(A_ACK, 1023, "R7 edge not pending after eoi");

    @(posedge clk); #1;
    fwd_edge[3] = 1; fwd_src[9 +: 3] = 3'd2;
    pulse(3);
    rd_pulse(3, (2 << 10) | 3, "R10 ack during pulse");
    chk_irq(0, "R10 active line low");
    wr(A_EOI, (2 << 10) | 3);
    chk_irq(1, "R10 pulse kept pending");
    rd(A_ACK, (2 << 10) | 3, "R10 re-acked");
    wr(A_EOI, 3);
    rd(A_ACK, 1023, "R10 nothing left");

    @(negedge clk);
    finish_up();
  end
endmodule